// File: doc/BRIEF.md
# Ring Receive Statistics Counters

This block keeps the receive statistics of a token ring station and returns them to a host through a 16-bit read port. The receive path sends single-cycle event strobes: start delimiter, token bit, end of the source address, data byte, end delimiter, error condition, duplicate discard and format discard. The block turns these strobes into a frame count, a byte count for the current frame, and two error tallies.

The host issues a read by raising `req_valid` for one cycle with an address. The port accepts a request every cycle and has no back-pressure, so there is no ready signal. Exactly one cycle later `rsp_valid` is high with the data. The 32-bit byte count is returned in two reads. The first read returns the upper half and takes a snapshot of the lower half. If the next host access is another byte-count read, it returns that snapshot. Both error tallies clear when the error register is read.

Top module: `ring_rx_stats`

## Requirements
- R1: The frame count is 16 bits and starts at 0 after reset. It increases by one in each cycle where `ev_sd` and `ev_token` are both high, and it steps from FFFFh to 0000h.
- R2: After an `ev_sa_done` strobe, each `ev_byte` strobe increases the 32-bit byte count by one. The count wraps modulo 2^32. Byte strobes in the same cycle as `ev_sa_done` are not counted.
- R3: Counting stops at `ev_ed`, or at `ev_sd` together with `ev_err`. Byte strobes in that cycle and in later cycles are ignored until the next `ev_sa_done`.
- R4: A frame start (`ev_sd` and `ev_token`) clears the byte count to zero and stops counting. The count stays at zero until the next `ev_sa_done`.
- R5: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, and low at all other times, including during reset.
- R6: Address map on `req_addr`. Address 0 returns the frame count. Address 1 returns the byte count. Address 2 returns the duplicate tally in bits 15:8 and the format tally in bits 7:0. Address 3 returns 0000h. Every value reflects the events of the cycles before the request cycle.
- R7: A byte-count read that follows a completed pair, or any other access, returns bits 31:16 and latches bits 15:0. If the next host access is also a byte-count read, it returns the latched bits 15:0.
- R8: A read of address 0, 2 or 3 between two byte-count reads makes the second byte-count read return bits 31:16 again, and that read starts a new pair.
- R9: Each 8-bit error tally counts its own discard strobe and stays at FFh instead of wrapping.
- R10: A read of address 2 clears both tallies. If a discard strobe arrives in the same cycle as that read, the matching tally ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_sd | input | 1 | Start delimiter seen |
| ev_token | input | 1 | Token bit value qualifying `ev_sd` |
| ev_sa_done | input | 1 | Source address field finished |
| ev_byte | input | 1 | One data byte received |
| ev_ed | input | 1 | End delimiter seen |
| ev_err | input | 1 | Error condition qualifying `ev_sd` |
| ev_dup_drop | input | 1 | Frame dropped as a duplicate |
| ev_fmt_drop | input | 1 | Frame dropped for a format fault |
| req_valid | input | 1 | Host read request |
| req_addr | input | 2 | Register select |
| rsp_valid | output | 1 | Read data valid, one cycle after the request |
| rsp_data | output | 16 | Read data |

## Verification
Every counter update is due one clock edge after its strobe. Every read response is due one edge after its request and shows the counter values as they stood before the request cycle's own events. The bench drives inputs and samples outputs at the falling edge. Its reference model computes the expected read value from the state before each cycle, and only then applies that cycle's events, so each response is compared exactly one edge after it was requested. The pairing of byte-count reads and the clearing of the tallies are modelled per host access, not per cycle, so idle cycles do not disturb the expected pair.

// File: rtl/rrs_pkg.sv
`timescale 1ns/1ps
package rrs_pkg;
  typedef enum logic [1:0] {
    RA_FRAMES = 2'd0,
    RA_BYTES  = 2'd1,
    RA_ERRORS = 2'd2,
    RA_SPARE  = 2'd3
  } rrs_addr_e;

  localparam int unsigned ERR_KINDS = 2;
  localparam int unsigned ERR_DUP   = 1;
  localparam int unsigned ERR_FMT   = 0;
endpackage

// File: rtl/rrs_frame_cnt.sv
`timescale 1ns/1ps
module rrs_frame_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + 1'b1;
  end
endmodule

// File: rtl/rrs_byte_cnt.sv
`timescale 1ns/1ps
module rrs_byte_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_start,
  input  logic         stop,
  input  logic         arm,
  input  logic         byte_vld,
  output logic [W-1:0] count
);
  logic active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      active <= 1'b0;
    end else if (frame_start) begin
      count  <= '0;
      active <= 1'b0;
    end else if (stop) begin
      active <= 1'b0;
    end else if (arm) begin
      active <= 1'b1;
    end else if (active && byte_vld) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/rrs_sat_cnt.sv
`timescale 1ns/1ps
module rrs_sat_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                   count <= '0;
    else if (clr)                 count <= inc ? W'(1) : '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end
endmodule

// File: rtl/rrs_host_port.sv
`timescale 1ns/1ps
module rrs_host_port
  import rrs_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned BYTE_W  = 32,
  parameter int unsigned ERR_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         req_addr,
  input  logic [FRAME_W-1:0] frames,
  input  logic [BYTE_W-1:0]  bytes_cnt,
  input  logic [ERR_W-1:0]   dup_cnt,
  input  logic [ERR_W-1:0]   fmt_cnt,
  output logic               clr_err,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data
);
  localparam int unsigned HALF = BYTE_W / 2;

  rrs_addr_e          sel;
  logic               low_next;
  logic [HALF-1:0]    low_snap;

  assign sel     = rrs_addr_e'(req_addr);
  assign clr_err = req_valid && (sel == RA_ERRORS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      low_next  <= 1'b0;
      low_snap  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        low_next <= 1'b0;
        unique case (sel)
          RA_FRAMES: rsp_data <= DATA_W'(frames);
          RA_BYTES: begin
            if (low_next) begin
              rsp_data <= DATA_W'(low_snap);
            end else begin
              rsp_data <= DATA_W'(bytes_cnt[BYTE_W-1:HALF]);
              low_snap <= bytes_cnt[HALF-1:0];
              low_next <= 1'b1;
            end
          end
          RA_ERRORS: rsp_data <= DATA_W'({dup_cnt, fmt_cnt});
          default:   rsp_data <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ring_rx_stats.sv
`timescale 1ns/1ps
module ring_rx_stats
  import rrs_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned ERR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_sd,
  input  logic              ev_token,
  input  logic              ev_sa_done,
  input  logic              ev_byte,
  input  logic              ev_ed,
  input  logic              ev_err,
  input  logic              ev_dup_drop,
  input  logic              ev_fmt_drop,
  input  logic              req_valid,
  input  logic [1:0]        req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int unsigned BYTE_W = 2 * DATA_W;

  logic                 frame_start;
  logic                 byte_stop;
  logic                 clr_err;
  logic [FRAME_W-1:0]   frame_q;
  logic [BYTE_W-1:0]    byte_q;
  logic [ERR_KINDS-1:0] err_ev;
  logic [ERR_W-1:0]     err_q [ERR_KINDS];

  assign frame_start     = ev_sd && ev_token;
  assign byte_stop       = ev_ed || (ev_sd && ev_err);
  assign err_ev[ERR_DUP] = ev_dup_drop;
  assign err_ev[ERR_FMT] = ev_fmt_drop;

  rrs_frame_cnt #(.W(FRAME_W)) u_frames (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (frame_start),
    .count (frame_q)
  );

  rrs_byte_cnt #(.W(BYTE_W)) u_bytes (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .stop        (byte_stop),
    .arm         (ev_sa_done),
    .byte_vld    (ev_byte),
    .count       (byte_q)
  );

  for (genvar k = 0; k < ERR_KINDS; k++) begin : g_err
    rrs_sat_cnt #(.W(ERR_W)) u_tally (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (err_ev[k]),
      .clr   (clr_err),
      .count (err_q[k])
    );
  end

  rrs_host_port #(
    .DATA_W  (DATA_W),
    .FRAME_W (FRAME_W),
    .BYTE_W  (BYTE_W),
    .ERR_W   (ERR_W)
  ) u_host (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .frames    (frame_q),
    .bytes_cnt (byte_q),
    .dup_cnt   (err_q[ERR_DUP]),
    .fmt_cnt   (err_q[ERR_FMT]),
    .clr_err   (clr_err),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );
endmodule

// File: rtl/rrs_checker.sv
`timescale 1ns/1ps
module rrs_checker #(
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned BYTE_W  = 32,
  parameter int unsigned ERR_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ev_sd,
  input logic               ev_token,
  input logic               ev_dup_drop,
  input logic               req_valid,
  input logic [1:0]         req_addr,
  input logic               rsp_valid,
  input logic [FRAME_W-1:0] frame_q,
  input logic [BYTE_W-1:0]  byte_q,
  input logic [ERR_W-1:0]   dup_q
);
  logic start, err_rd;
  assign start  = ev_sd && ev_token;
  assign err_rd = req_valid && (req_addr == 2'd2);

  a_r1_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> frame_q == FRAME_W'($past(frame_q) + 1'b1));

  a_r1_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(frame_q));

  a_r4_byte_clear: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> byte_q == '0);

  a_r5_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r5_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r9_dup_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (dup_q == '1 && !err_rd) |=> dup_q == '1);

  a_r10_dup_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (err_rd && !ev_dup_drop) |=> dup_q == '0);

  a_r10_dup_keeps_event: assert property (@(posedge clk) disable iff (!rst_n)
    (err_rd && ev_dup_drop) |=> dup_q == ERR_W'(1));
endmodule

bind ring_rx_stats rrs_checker #(
  .FRAME_W (FRAME_W),
  .BYTE_W  (BYTE_W),
  .ERR_W   (ERR_W)
) u_rrs_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .ev_sd       (ev_sd),
  .ev_token    (ev_token),
  .ev_dup_drop (ev_dup_drop),
  .req_valid   (req_valid),
  .req_addr    (req_addr),
  .rsp_valid   (rsp_valid),
  .frame_q     (frame_q),
  .byte_q      (byte_q),
  .dup_q       (err_q[rrs_pkg::ERR_DUP])
);

// File: tb/test_ring_rx_stats.sv
`timescale 1ns/1ps
module test_ring_rx_stats;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_sd = 0, ev_token = 0, ev_sa_done = 0, ev_byte = 0;
  logic        ev_ed = 0, ev_err = 0, ev_dup_drop = 0, ev_fmt_drop = 0;
  logic        req_valid = 0;
  logic [1:0]  req_addr = 0;
  logic        rsp_valid;
  logic [15:0] rsp_data;

  int n_checks = 0;
  int n_fails  = 0;

  // reference model state
  logic [15:0] m_frame = 0;
  logic [31:0] m_bytes = 0;
  bit          m_act = 0;
  logic [7:0]  m_dup = 0, m_fmt = 0;
  bit          m_low_next = 0;
  logic [15:0] m_snap = 0;

  always #2.5 clk = ~clk;

  ring_rx_stats i_ring_rx_stats (
    .clk (clk), .rst_n (rst_n),
    .ev_sd (ev_sd), .ev_token (ev_token), .ev_sa_done (ev_sa_done),
    .ev_byte (ev_byte), .ev_ed (ev_ed), .ev_err (ev_err),
    .ev_dup_drop (ev_dup_drop), .ev_fmt_drop (ev_fmt_drop),
    .req_valid (req_valid), .req_addr (req_addr),
    .rsp_valid (rsp_valid), .rsp_data (rsp_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] model_read(input logic [1:0] a);
    logic [15:0] r;
    r = 16'h0;
    if (a == 2'd1) begin
      if (m_low_next) begin r = m_snap; m_low_next = 0; end
      else begin r = m_bytes[31:16]; m_snap = m_bytes[15:0]; m_low_next = 1; end
    end else begin
      m_low_next = 0;
      if (a == 2'd0) r = m_frame;
      else if (a == 2'd2) r = {m_dup, m_fmt};
    end
    return r;
  endfunction

  function automatic void model_events();
    bit clr;
    clr = req_valid && req_addr == 2'd2;
    if (ev_sd && ev_token) begin m_frame++; m_bytes = 0; m_act = 0; end
    else if (ev_ed || (ev_sd && ev_err)) m_act = 0;
    else if (ev_sa_done) m_act = 1;
    else if (m_act && ev_byte) m_bytes++;
    if (clr) m_dup = ev_dup_drop ? 8'd1 : 8'd0;
    else if (ev_dup_drop && m_dup != 8'hFF) m_dup++;
    if (clr) m_fmt = ev_fmt_drop ? 8'd1 : 8'd0;
    else if (ev_fmt_drop && m_fmt != 8'hFF) m_fmt++;
  endfunction

  task automatic clear_inputs();
    {ev_sd, ev_token, ev_sa_done, ev_byte, ev_ed, ev_err, ev_dup_drop, ev_fmt_drop} = '0;
    req_valid = 0;
    req_addr  = 0;
  endtask

  // one cycle: inputs already set at a falling edge; result checked at the next one
  task automatic tick(input string tag);
    logic [15:0] e;
    bit          want;
    want = req_valid;
    e = want ? model_read(req_addr) : 16'h0;
    model_events();
    @(posedge clk);
    @(negedge clk);
    check("R5", {31'b0, rsp_valid}, {31'b0, want});
    if (want) check(tag, {16'b0, rsp_data}, {16'b0, e});
    clear_inputs();
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    req_valid = 1; req_addr = a;
    tick(tag);
  endtask

  task automatic bytes_n(input int n);
    for (int i = 0; i < n; i++) begin ev_byte = 1; tick("R2"); end
  endtask

  task automatic frame_start_arm();
    ev_sd = 1; ev_token = 1; tick("R4");
    ev_sa_done = 1; ev_byte = 1; tick("R2");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    clear_inputs();
    repeat (3) @(negedge clk);
    check("R5", {31'b0, rsp_valid}, 32'd0);
    rst_n = 1;

    // R6: reset values through every address
    for (int a = 0; a < 4; a++) rd(2'(a), "R6");

    // R2: count after source address
    frame_start_arm();
    bytes_n(5);
    rd(2'd1, "R2");
    rd(2'd1, "R2");
    // R3: end delimiter stops counting
    ev_ed = 1; ev_byte = 1; tick("R3");
    bytes_n(3);
    rd(2'd1, "R3");
    rd(2'd1, "R3");
    // R3: start delimiter with error stops counting
    frame_start_arm();
    bytes_n(4);
    ev_sd = 1; ev_err = 1; ev_byte = 1; tick("R3");
    bytes_n(2);
    rd(2'd1, "R3");
    rd(2'd1, "R3");
    // R4: new frame clears the count
    ev_sd = 1; ev_token = 1; tick("R4");
    bytes_n(2);
    rd(2'd1, "R4");
    rd(2'd1, "R4");

    // R7 / R8: pairing and interruption
    frame_start_arm();
    bytes_n(7);
    rd(2'd1, "R7");
    bytes_n(2);
    rd(2'd1, "R7");
    rd(2'd1, "R8");
    rd(2'd0, "R8");
    rd(2'd1, "R8");
    rd(2'd1, "R8");
    rd(2'd1, "R8");
    rd(2'd3, "R8");
    rd(2'd1, "R8");

    // R9: saturation of both tallies
    for (int i = 0; i < 300; i++) begin ev_dup_drop = 1; ev_fmt_drop = (i < 260); tick("R9"); end
    rd(2'd2, "R9");
    rd(2'd2, "R10");
    // R10: event in the clearing cycle survives
    ev_dup_drop = 1; ev_fmt_drop = 1; tick("R10");
    ev_dup_drop = 1; req_valid = 1; req_addr = 2'd2; tick("R10");
    rd(2'd2, "R10");

    // R1: full wrap of the frame count
    rd(2'd0, "R1");
    for (int i = 0; i < 65536; i++) begin ev_sd = 1; ev_token = 1; tick("R1"); end
    rd(2'd0, "R1");

    // constrained random mix
    for (int i = 0; i < 20000; i++) begin
      ev_sd       = ($urandom % 40) == 0;
      ev_token    = ($urandom % 4) != 0;
      ev_err      = ($urandom % 8) == 0;
      ev_sa_done  = ($urandom % 12) == 0;
      ev_byte     = ($urandom % 2) == 0;
      ev_ed       = ($urandom % 30) == 0;
      ev_dup_drop = ($urandom % 6) == 0;
      ev_fmt_drop = ($urandom % 6) == 0;
      req_valid   = ($urandom % 4) == 0;
      req_addr    = 2'($urandom % 4);
      case (req_addr)
        2'd0:    tick("R1");
        2'd1:    tick("R7");
        2'd2:    tick("R10");
        default: tick("R6");
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule